// File: doc/BRIEF.md
# Convolution Window Vector Sequencer

This block feeds a weight-stationary multiply-accumulate array that computes a 2D convolution. Every array column holds one output-channel kernel flattened over kernel rows, kernel columns and input channels, so the array needs, for each output pixel, one column vector of input activations laid out in the same flattened order. The sequencer walks the output pixels, reads the matching activation window from an on-chip activation memory through a read port with one cycle of latency, and hands each assembled vector to the array over a valid/ready interface, tagged with the output coordinate it belongs to.

When the flattened window depth is larger than the number of array rows, every pixel is sent as several consecutive row tiles. Each vector carries a first-tile and a last-tile flag so that the downstream logic can add up partial sums. Rows beyond the end of the window in the last tile are zero. Once the final tile of the final pixel is accepted, the block pulses a done signal and stays idle until it is told that a fresh weight set is resident. The same idle state follows reset.

The convolution uses unit stride and no padding. With an input plane of `IMG_H` x `IMG_W` and a kernel of `KER_R` x `KER_S`, the output is `IMG_H-KER_R+1` rows by `IMG_W-KER_S+1` columns.

Top module: `conv_window_seq`

## Requirements
- R1: The activation address for channel c, image row y and image column x is (c*IMG_H + y)*IMG_W + x. Data requested with `act_rd_en` high appears on `act_rd_data` one cycle later. It lands in the row slot for which it was requested.
- R2: Flattened window index k = c*KER_R*KER_S + r*KER_S + s selects input (e+r, f+s, c). Row slot j of depth tile t carries k = t*ROWS + j.
- R3: Row slots with k at or beyond KER_R*KER_S*CHANNELS are driven with zero.
- R4: Output pixels are issued in raster order, with f varying fastest and then e, and `vec_e`/`vec_f` give the coordinate. Each pixel is issued as ceil(depth/ROWS) consecutive tiles before the next pixel starts.
- R5: `vec_first` is high only on tile 0 of a pixel and `vec_last` only on its final tile.
- R6: While `vec_valid` is high and `vec_ready` is low, `vec_valid`, `vec_data`, `vec_e`, `vec_f`, `vec_first` and `vec_last` hold their values.
- R7: `weights_done` is high for exactly one cycle: the cycle after the final tile of pixel (E-1, F-1) is accepted.
- R8: After reset and after `weights_done`, the block makes no reads and presents no vector until `weights_loaded` is seen high. While a pass is streaming, `weights_loaded` has no effect.
- R9: While reset is held, `vec_valid`, `weights_done` and `act_rd_en` are low.
- R10: For each vector, the number of activation reads equals the number of live rows in its tile, min(ROWS, depth - t*ROWS). Zero rows cause no reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| weights_loaded | input | 1 | A fresh weight set is resident; starts one streaming pass |
| weights_done | output | 1 | One-cycle pulse after the last vector of a pass is accepted |
| act_rd_en | output | 1 | Activation memory read request |
| act_addr | output | cw(CHANNELS*IMG_H*IMG_W) | Activation memory read address |
| act_rd_data | input | DW | Read data, valid one cycle after the request |
| vec_valid | output | 1 | Vector available to the array |
| vec_ready | input | 1 | Array accepts the vector |
| vec_data | output | ROWS*DW | Row slot j occupies bits j*DW +: DW |
| vec_e | output | cw(IMG_H-KER_R+1) | Output row of the vector |
| vec_f | output | cw(IMG_W-KER_S+1) | Output column of the vector |
| vec_first | output | 1 | First depth tile of this pixel |
| vec_last | output | 1 | Last depth tile of this pixel |

## Verification
The bench builds the block for a 4x5 image with two channels, a 2x3 kernel and a 5-row array. This gives a 3x3 output and a flattened depth of 12 split into tiles of 5, 5 and 2 live rows. That setting makes the last tile zero-pad three rows. It also makes the channel boundary fall inside the middle tile, and the non-square kernel exposes any swap of the r and s strides. Two full passes run with varied back-pressure. The second pass raises `weights_loaded` in the middle of streaming, which checks that the pixel order and the single done pulse are unaffected.

// File: rtl/cws_pkg.sv
package cws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GATHER,
    ST_DRAIN,
    ST_PRESENT
  } seq_state_e;

  // counter width that stays legal when the count is one
  function automatic int unsigned cw(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int unsigned tile_count(int unsigned depth, int unsigned rows);
    return (depth + rows - 1) / rows;
  endfunction

  // channel-planar activation layout
  function automatic int unsigned plane_addr(int unsigned ch, int unsigned y, int unsigned x,
                                             int unsigned h, int unsigned w);
    return (ch * h + y) * w + x;
  endfunction

endpackage

// File: rtl/cws_pixel_ctr.sv
module cws_pixel_ctr #(
  parameter int unsigned OUT_E = 6,
  parameter int unsigned OUT_F = 6,
  parameter int unsigned TILES = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              adv,
  output logic [cws_pkg::cw(OUT_E)-1:0]     e,
  output logic [cws_pkg::cw(OUT_F)-1:0]     f,
  output logic [cws_pkg::cw(TILES)-1:0]     tile,
  output logic                              first_tile,
  output logic                              last_tile,
  output logic                              final_vec
);
  localparam int unsigned EW = cws_pkg::cw(OUT_E);
  localparam int unsigned FW = cws_pkg::cw(OUT_F);
  localparam int unsigned TW = cws_pkg::cw(TILES);

  logic e_end, f_end;

  assign e_end      = (e == EW'(OUT_E - 1));
  assign f_end      = (f == FW'(OUT_F - 1));
  assign first_tile = (tile == TW'(0));
  assign last_tile  = (tile == TW'(TILES - 1));
  assign final_vec  = last_tile && e_end && f_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e    <= '0;
      f    <= '0;
      tile <= '0;
    end else if (adv) begin
      if (last_tile) begin
        tile <= '0;
        if (f_end) begin
          f <= '0;
          e <= e_end ? '0 : e + 1'b1;
        end else begin
          f <= f + 1'b1;
        end
      end else begin
        tile <= tile + 1'b1;
      end
    end
  end

  p_coord_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(e) < OUT_E) && (32'(f) < OUT_F) && (32'(tile) < TILES));

  p_tile_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !last_tile |=> $stable(e) && $stable(f));

endmodule

// File: rtl/cws_depth_walker.sv
module cws_depth_walker #(
  parameter int unsigned CHANNELS = 4,
  parameter int unsigned KER_R    = 3,
  parameter int unsigned KER_S    = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                restart,
  input  logic                                step,
  output logic [cws_pkg::cw(CHANNELS)-1:0]    ch,
  output logic [cws_pkg::cw(KER_R)-1:0]       kr,
  output logic [cws_pkg::cw(KER_S)-1:0]       ks,
  output logic                                live
);
  localparam int unsigned CW_ = cws_pkg::cw(CHANNELS);
  localparam int unsigned RW  = cws_pkg::cw(KER_R);
  localparam int unsigned SW  = cws_pkg::cw(KER_S);

  logic s_end, r_end, c_end;

  assign s_end = (ks == SW'(KER_S - 1));
  assign r_end = (kr == RW'(KER_R - 1));
  assign c_end = (ch == CW_'(CHANNELS - 1));

  // innermost s, then r, then channel: matches the column flattening
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch   <= '0;
      kr   <= '0;
      ks   <= '0;
      live <= 1'b1;
    end else if (restart) begin
      ch   <= '0;
      kr   <= '0;
      ks   <= '0;
      live <= 1'b1;
    end else if (step && live) begin
      if (s_end) begin
        ks <= '0;
        if (r_end) begin
          kr <= '0;
          if (c_end) begin
            ch   <= '0;
            live <= 1'b0;
          end else begin
            ch <= ch + 1'b1;
          end
        end else begin
          kr <= kr + 1'b1;
        end
      end else begin
        ks <= ks + 1'b1;
      end
    end
  end

  p_walker_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(ch) < CHANNELS) && (32'(kr) < KER_R) && (32'(ks) < KER_S));

  p_exhausted_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !live && !restart |=> !live);

endmodule

// File: rtl/cws_row_buffer.sv
module cws_row_buffer #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned DW   = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cap_en,
  input  logic [cws_pkg::cw(ROWS)-1:0]   cap_slot,
  input  logic                           cap_live,
  input  logic [DW-1:0]                  rd_data,
  output logic [ROWS*DW-1:0]             vec
);
  localparam int unsigned SLW = cws_pkg::cw(ROWS);

  // request side delayed by one cycle to meet the read latency
  logic           p_en;
  logic [SLW-1:0] p_slot;
  logic           p_live;
  logic [DW-1:0]  slot_q [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_en   <= 1'b0;
      p_slot <= '0;
      p_live <= 1'b0;
    end else begin
      p_en   <= cap_en;
      p_slot <= cap_slot;
      p_live <= cap_live;
    end
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (p_en && (p_slot == SLW'(g))) begin
        slot_q[g] <= p_live ? rd_data : '0;
      end
    end
    assign vec[g*DW +: DW] = slot_q[g];
  end

  p_slot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    p_en |-> (32'(p_slot) < ROWS));

endmodule

// File: rtl/conv_window_seq.sv
module conv_window_seq #(
  parameter int unsigned IMG_H    = 8,
  parameter int unsigned IMG_W    = 8,
  parameter int unsigned CHANNELS = 4,
  parameter int unsigned KER_R    = 3,
  parameter int unsigned KER_S    = 3,
  parameter int unsigned ROWS     = 16,
  parameter int unsigned DW       = 8
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic                                             weights_loaded,
  output logic                                             weights_done,
  output logic                                             act_rd_en,
  output logic [cws_pkg::cw(CHANNELS*IMG_H*IMG_W)-1:0]     act_addr,
  input  logic [DW-1:0]                                    act_rd_data,
  output logic                                             vec_valid,
  input  logic                                             vec_ready,
  output logic [ROWS*DW-1:0]                               vec_data,
  output logic [cws_pkg::cw(IMG_H-KER_R+1)-1:0]            vec_e,
  output logic [cws_pkg::cw(IMG_W-KER_S+1)-1:0]            vec_f,
  output logic                                             vec_first,
  output logic                                             vec_last
);
  import cws_pkg::*;

  localparam int unsigned OUT_E = IMG_H - KER_R + 1;
  localparam int unsigned OUT_F = IMG_W - KER_S + 1;
  localparam int unsigned DEPTH = CHANNELS * KER_R * KER_S;
  localparam int unsigned TILES = tile_count(DEPTH, ROWS);
  localparam int unsigned AW    = cw(CHANNELS * IMG_H * IMG_W);
  localparam int unsigned SLW   = cw(ROWS);
  localparam int unsigned TW    = cw(TILES);

  seq_state_e state_q;
  logic [SLW-1:0] slot_q;
  logic done_q;

  // named internal events
  logic issue, fire, restart, last_slot;
  logic first_tile, last_tile, final_vec;
  logic [TW-1:0] tile;
  logic [cw(CHANNELS)-1:0] ch;
  logic [cw(KER_R)-1:0] kr;
  logic [cw(KER_S)-1:0] ks;
  logic live;

  assign issue     = (state_q == ST_GATHER);
  assign fire      = (state_q == ST_PRESENT) && vec_ready;
  assign restart   = fire && last_tile;
  assign last_slot = (slot_q == SLW'(ROWS - 1));

  cws_pixel_ctr #(.OUT_E(OUT_E), .OUT_F(OUT_F), .TILES(TILES)) u_pix (
    .clk(clk), .rst_n(rst_n), .adv(fire),
    .e(vec_e), .f(vec_f), .tile(tile),
    .first_tile(first_tile), .last_tile(last_tile), .final_vec(final_vec)
  );

  cws_depth_walker #(.CHANNELS(CHANNELS), .KER_R(KER_R), .KER_S(KER_S)) u_walk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step(issue),
    .ch(ch), .kr(kr), .ks(ks), .live(live)
  );

  cws_row_buffer #(.ROWS(ROWS), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .cap_en(issue), .cap_slot(slot_q), .cap_live(live),
    .rd_data(act_rd_data), .vec(vec_data)
  );

  assign act_rd_en = issue && live;
  assign act_addr  = AW'(plane_addr(32'(ch), 32'(vec_e) + 32'(kr),
                                    32'(vec_f) + 32'(ks), IMG_H, IMG_W));

  assign vec_valid    = (state_q == ST_PRESENT);
  assign vec_first    = first_tile;
  assign vec_last     = last_tile;
  assign weights_done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fire && final_vec;
      unique case (state_q)
        ST_IDLE: begin
          slot_q <= '0;
          if (weights_loaded) state_q <= ST_GATHER;
        end
        ST_GATHER: begin
          slot_q <= slot_q + 1'b1;
          if (last_slot) state_q <= ST_DRAIN;
        end
        ST_DRAIN: state_q <= ST_PRESENT;
        ST_PRESENT: begin
          slot_q <= '0;
          if (vec_ready) state_q <= final_vec ? ST_IDLE : ST_GATHER;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_data) && $stable(vec_e)
      && $stable(vec_f) && $stable(vec_first) && $stable(vec_last));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    weights_done |=> !weights_done);

  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    weights_done |-> $past(vec_valid && vec_ready && vec_last
      && (32'(vec_e) == OUT_E - 1) && (32'(vec_f) == OUT_F - 1)));

  p_no_read_present_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !act_rd_en);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !act_rd_en && !vec_valid);

  p_addr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    act_rd_en |-> (32'(act_addr) < CHANNELS * IMG_H * IMG_W));

endmodule

// File: tb/test_conv_window_seq.sv
module test_conv_window_seq;
  localparam int H = 4, W = 5, C = 2, R = 2, S = 3, ROWS = 5, DW = 8;
  localparam int E = H - R + 1, F = W - S + 1, DEPTH = C * R * S;
  localparam int TILES = (DEPTH + ROWS - 1) / ROWS;
  localparam int AW = $clog2(C * H * W);

  typedef struct packed { int stall; int e; int f; } row_t;
  // per pixel: back-pressure cycles, expected raster coordinate (R4)
  localparam row_t TBL [9] = '{
    '{0, 0, 0}, '{2, 0, 1}, '{0, 0, 2}, '{1, 1, 0}, '{3, 1, 1},
    '{0, 1, 2}, '{1, 2, 0}, '{0, 2, 1}, '{2, 2, 2}};

  logic clk = 0, rst_n = 0, weights_loaded = 0, vec_ready = 0;
  logic weights_done, act_rd_en, vec_valid, vec_first, vec_last;
  logic [AW-1:0] act_addr;
  logic [DW-1:0] act_rd_data = '0;
  logic [ROWS*DW-1:0] vec_data;
  logic [1:0] vec_e, vec_f;

  int checks = 0, fails = 0, reads = 0, dones = 0;

  always #4 clk = ~clk;

  conv_window_seq #(.IMG_H(H), .IMG_W(W), .CHANNELS(C), .KER_R(R), .KER_S(S),
                    .ROWS(ROWS), .DW(DW)) i_conv_window_seq (
    .clk(clk), .rst_n(rst_n), .weights_loaded(weights_loaded),
    .weights_done(weights_done), .act_rd_en(act_rd_en), .act_addr(act_addr),
    .act_rd_data(act_rd_data), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_data(vec_data), .vec_e(vec_e), .vec_f(vec_f),
    .vec_first(vec_first), .vec_last(vec_last));

  function automatic int memval(int a);
    return ((a * 7 + 3) % 251) + 1;
  endfunction

  function automatic int expect_slot(int e, int f, int t, int j);
    int k, c, r, s;
    k = t * ROWS + j;
    if (k >= DEPTH) return 0;
    c = k / (R * S);
    r = (k / S) % R;
    s = k % S;
    return memval((c * H + e + r) * W + f + s);
  endfunction

  function automatic int live_rows(int t);
    int rem;
    rem = DEPTH - t * ROWS;
    return (rem < ROWS) ? rem : ROWS;
  endfunction

  // one-cycle-latency activation memory
  always @(posedge clk) if (act_rd_en) act_rd_data <= DW'(memval(int'(act_addr)));
  always @(negedge clk) begin
    if (act_rd_en) reads++;
    if (weights_done) dones++;
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run_pass(input bit poke);
    int base, done_base;
    logic [ROWS*DW-1:0] held;
    @(negedge clk); weights_loaded = 1;
    @(negedge clk); weights_loaded = 0;
    base = reads;
    done_base = dones;
    for (int p = 0; p < 9; p++) begin
      for (int t = 0; t < TILES; t++) begin
        int waited = 0;
        while (!vec_valid && waited < 60) begin @(negedge clk); waited++; end
        chk(vec_valid, "R4", "vector not presented", int'(vec_valid), 1);
        chk(reads - base == live_rows(t), "R10", "reads per vector", reads - base, live_rows(t));
        chk(int'(vec_e) == TBL[p].e && int'(vec_f) == TBL[p].f, "R4", "coordinate e*10+f",
            int'(vec_e) * 10 + int'(vec_f), TBL[p].e * 10 + TBL[p].f);
        chk(vec_first == (t == 0), "R5", "first flag", int'(vec_first), int'(t == 0));
        chk(vec_last == (t == TILES - 1), "R5", "last flag", int'(vec_last), int'(t == TILES - 1));
        for (int j = 0; j < ROWS; j++) begin
          int ex = expect_slot(TBL[p].e, TBL[p].f, t, j);
          int ac = int'(vec_data[j*DW +: DW]);
          if (t * ROWS + j >= DEPTH) chk(ac == ex, "R3", "padding slot", ac, ex);
          else chk(ac == ex, "R2", "window slot (R1 addressing)", ac, ex);
        end
        held = vec_data;
        for (int k = 0; k < TBL[p].stall; k++) begin
          if (poke && k == 0 && p == 4) weights_loaded = 1;
          @(negedge clk);
          weights_loaded = 0;
          chk(vec_valid && vec_data == held && int'(vec_e) == TBL[p].e, "R6",
              "hold under stall", int'(vec_valid), 1);
        end
        vec_ready = 1;
        @(negedge clk);
        vec_ready = 0;
        base = reads;
        chk(weights_done == (p == 8 && t == TILES - 1), "R7", "done after handshake",
            int'(weights_done), int'(p == 8 && t == TILES - 1));
      end
    end
    @(negedge clk);
    chk(!weights_done, "R7", "done width", int'(weights_done), 0);
    chk(dones - done_base == 1, "R7", "done pulses per pass", dones - done_base, 1);
    base = reads;
    for (int k = 0; k < 6; k++) @(negedge clk);
    chk(!vec_valid && reads == base, "R8", "idle after done", reads - base, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!vec_valid && !weights_done && !act_rd_en, "R9", "reset outputs",
        int'({vec_valid, weights_done, act_rd_en}), 0);
    rst_n = 1;
    vec_ready = 1;
    for (int k = 0; k < 5; k++) @(negedge clk);
    chk(!vec_valid && reads == 0, "R8", "idle before weights_loaded", reads, 0);
    vec_ready = 0;
    run_pass(1'b0);
    run_pass(1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule